// File: doc/BRIEF.md
# Cluster Global Configuration Registers

This block is the shared configuration register file of a small multicore cluster. A single 64-bit register port serves every core. Each access carries the requesting core's index. Global registers describe the cluster, and they place and enable two attached peripheral windows: an interrupt controller and a power controller. Each core also owns a private register set. It holds a reset-vector base and a pointer that names one other core.

Each core reaches its own private set through the core-local window. Through the core-other window, the same offsets reach the private set of the core its pointer selects. This is how one core sets up another core's boot vector before releasing it. Every core's exception-base output follows its reset-base register at all times. The peripheral window outputs follow their base registers. A base register can be written only while its peripheral-present strap is high.

Top module: `cluster_cfg_regs`

## Requirements
- R1: After reset, both peripheral base registers read 0 and their enables are low. Every core's other pointer is 0. Every core's reset base reads 0xBFC00000 and its exception base is 0xFFFFFFFF_BFC00000. The global base holds the GBASE_RST parameter.
- R2: Read data appears on rdata_o, with rvalid_o high, in the cycle after the read request is accepted.
- R3: The global config register (0x0000) reads 0 and the revision register (0x0030) reads parameter REVISION (default 0x800). An offset not listed here reads 0, and writes to it change nothing.
- R4: The L2 config register (0x0130) reads with only bit 20 (bypass) set.
- R5: The per-core config register (window offset 0x10) reads NUM_CORES-1 in both windows.
- R6: The core-local window (addresses 0x2000-0x3FFF) acts on the requester's own set.
- R7: The core-other window (addresses 0x4000-0x5FFF) acts on the set selected by the requester's other pointer (offset 0x18).
- R8: A write to an other pointer stores wdata[2:0] only when that value is below NUM_CORES. Otherwise the pointer is unchanged.
- R9: The interrupt base register (0x0080) and the power base register (0x0088) each store wdata bits [47:15] plus bit 0. The write is taken only while the matching present strap is high. base_o carries the address bits and en_o carries bit 0.
- R10: The interrupt status register (0x00D0) and the power status register (0x00F0) read the matching present strap in bit 0.
- R11: The global base register (0x0008) stores wdata bits [47:15] and reads back that value. cp0_base_o carries the stored value shifted right by 4.
- R12: The reset base (offset 0x20) stores wdata bits [31:12]. The core's exception-base output is that value sign-extended from bit 31, and it updates in the cycle after a write through either window.
- R13: A requester index of NUM_CORES or more reads 0 from both per-core windows, and its writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Byte offset within the block |
| wdata_i | input | 64 | Write data |
| core_id_i | input | 3 | Requesting core index |
| rdata_o | output | 64 | Registered read data |
| rvalid_o | output | 1 | rdata_o holds the result of last cycle's read |
| intc_present_i | input | 1 | Interrupt controller present strap |
| pwr_present_i | input | 1 | Power controller present strap |
| intc_base_o | output | 64 | Interrupt controller window base |
| intc_en_o | output | 1 | Interrupt controller window enable |
| pwr_base_o | output | 64 | Power controller window base |
| pwr_en_o | output | 1 | Power controller window enable |
| gcr_base_o | output | 64 | Stored global base |
| cp0_base_o | output | 64 | Global base shifted right by 4 |
| exc_base_o | output | 64*NUM_CORES | Per-core exception base, core k at [64k+63:64k] |

## Verification
A corrupted other pointer does not show by itself. It shows in the next core-other access, which lands on the wrong core's set: a reset base written there moves a different exc_base_o slice one cycle later. The bench therefore reads through both windows after each pointer change and compares every exc_base_o slice. A rejected base write or pointer write that leaks through is seen on the window outputs, or on readback, in the very next cycle.

// File: rtl/cluster_cfg_pkg.sv
package cluster_cfg_pkg;
  localparam int AW = 16;
  localparam int DW = 64;

  localparam logic [AW-1:0] OFS_GCFG    = 16'h0000;
  localparam logic [AW-1:0] OFS_GBASE   = 16'h0008;
  localparam logic [AW-1:0] OFS_REV     = 16'h0030;
  localparam logic [AW-1:0] OFS_INTC    = 16'h0080;
  localparam logic [AW-1:0] OFS_PWR     = 16'h0088;
  localparam logic [AW-1:0] OFS_INTC_ST = 16'h00D0;
  localparam logic [AW-1:0] OFS_PWR_ST  = 16'h00F0;
  localparam logic [AW-1:0] OFS_L2CFG   = 16'h0130;

  // per-core window select in addr[15:13]
  localparam logic [2:0] WIN_LOCAL = 3'b001;
  localparam logic [2:0] WIN_OTHER = 3'b010;

  localparam logic [12:0] CL_CFG   = 13'h0010;
  localparam logic [12:0] CL_OTHER = 13'h0018;
  localparam logic [12:0] CL_RBASE = 13'h0020;

  localparam logic [DW-1:0] BASE_ADDR_MSK = 64'h0000_FFFF_FFFF_8000;
  localparam logic [DW-1:0] EN_MSK        = 64'h0000_0000_0000_0001;
  localparam logic [DW-1:0] RBASE_MSK     = 64'h0000_0000_FFFF_F000;
  localparam logic [DW-1:0] RBASE_RST     = 64'h0000_0000_BFC0_0000;
  localparam logic [DW-1:0] L2_BYPASS     = 64'h0000_0000_0010_0000;

  typedef enum logic [1:0] {WIN_NONE, WIN_LCL, WIN_OTH} win_e;

  function automatic logic [DW-1:0] sext32(input logic [DW-1:0] v);
    return {{32{v[31]}}, v[31:0]};
  endfunction
endpackage

// File: rtl/periph_win_reg.sv
module periph_win_reg
  import cluster_cfg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          present_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o,
  output logic [DW-1:0] base_o,
  output logic          en_o
);
  logic [DW-1:0] q;

  // address and enable land in one register: no partial state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q <= '0;
    else if (wr_i && present_i) q <= wdata_i & (BASE_ADDR_MSK | EN_MSK);
  end

  assign q_o    = q;
  assign base_o = q & BASE_ADDR_MSK;
  assign en_o   = q[0];

  // R9
  periph_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !present_i) |=> ($stable(base_o) && $stable(en_o)));
  // R9
  periph_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && present_i) |=> (base_o == ($past(wdata_i) & BASE_ADDR_MSK)
                             && en_o == $past(wdata_i[0])));
endmodule

// File: rtl/core_set.sv
module core_set
  import cluster_cfg_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_rb_i,
  input  logic          wr_oth_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rb_o,
  output logic [2:0]    oth_o,
  output logic [DW-1:0] exc_base_o
);
  localparam logic [3:0] NC = 4'(NUM_CORES);

  logic [DW-1:0] rb_q;
  logic [2:0]    oth_q;
  logic          oth_ok;

  assign oth_ok = {1'b0, wdata_i[2:0]} < NC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rb_q  <= RBASE_RST & RBASE_MSK;
      oth_q <= '0;
    end else begin
      if (wr_rb_i)            rb_q  <= wdata_i & RBASE_MSK;
      if (wr_oth_i && oth_ok) oth_q <= wdata_i[2:0];
    end
  end

  assign rb_o       = rb_q;
  assign oth_o      = oth_q;
  assign exc_base_o = sext32(rb_q);

  // R8
  oth_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_oth_i && ({1'b0, wdata_i[2:0]} >= NC)) |=> $stable(oth_o));
  // R12
  exc_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rb_i |=> (exc_base_o[31:0] == ($past(wdata_i[31:0]) & 32'hFFFF_F000)));
endmodule

// File: rtl/cluster_cfg_regs.sv
module cluster_cfg_regs
  import cluster_cfg_pkg::*;
#(
  parameter int              NUM_CORES = 4,
  parameter logic [DW-1:0]   REVISION  = 64'h800,
  parameter logic [DW-1:0]   GBASE_RST = 64'h0000_0000_1FBF_8000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic [2:0]              core_id_i,
  output logic [DW-1:0]           rdata_o,
  output logic                    rvalid_o,
  input  logic                    intc_present_i,
  input  logic                    pwr_present_i,
  output logic [DW-1:0]           intc_base_o,
  output logic                    intc_en_o,
  output logic [DW-1:0]           pwr_base_o,
  output logic                    pwr_en_o,
  output logic [DW-1:0]           gcr_base_o,
  output logic [DW-1:0]           cp0_base_o,
  output logic [NUM_CORES*DW-1:0] exc_base_o
);
  localparam logic [3:0]    NC      = 4'(NUM_CORES);
  localparam logic [DW-1:0] CL_CFGV = DW'(NUM_CORES - 1);

  logic          wr, rd, id_ok;
  win_e          win;
  logic [12:0]   cl_ofs;
  logic [2:0]    tgt;
  logic [DW-1:0] rb_all  [8];
  logic [2:0]    oth_all [8];
  logic [DW-1:0] intc_q, pwr_q, gbase_q, rdata_d;

  assign wr     = req_i && we_i;
  assign rd     = req_i && !we_i;
  assign id_ok  = {1'b0, core_id_i} < NC;
  assign cl_ofs = addr_i[12:0];

  always_comb begin
    win = WIN_NONE;
    if (id_ok && addr_i[15:13] == WIN_LOCAL) win = WIN_LCL;
    if (id_ok && addr_i[15:13] == WIN_OTHER) win = WIN_OTH;
  end

  assign tgt = (win == WIN_OTH) ? oth_all[core_id_i] : core_id_i;

  // per-core sets, padded to 8 so a 3-bit index never leaves the array
  for (genvar k = 0; k < 8; k++) begin : g_core
    if (k < NUM_CORES) begin : g_on
      logic wr_rb, wr_oth;
      assign wr_rb  = wr && win != WIN_NONE && cl_ofs == CL_RBASE && tgt == 3'(k);
      assign wr_oth = wr && win != WIN_NONE && cl_ofs == CL_OTHER && tgt == 3'(k);
      core_set #(.NUM_CORES(NUM_CORES)) u_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_rb_i    (wr_rb),
        .wr_oth_i   (wr_oth),
        .wdata_i    (wdata_i),
        .rb_o       (rb_all[k]),
        .oth_o      (oth_all[k]),
        .exc_base_o (exc_base_o[k*DW +: DW])
      );
    end else begin : g_off
      assign rb_all[k]  = '0;
      assign oth_all[k] = '0;
    end
  end

  periph_win_reg u_intc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr && addr_i == OFS_INTC),
    .present_i (intc_present_i),
    .wdata_i   (wdata_i),
    .q_o       (intc_q),
    .base_o    (intc_base_o),
    .en_o      (intc_en_o)
  );

  periph_win_reg u_pwr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr && addr_i == OFS_PWR),
    .present_i (pwr_present_i),
    .wdata_i   (wdata_i),
    .q_o       (pwr_q),
    .base_o    (pwr_base_o),
    .en_o      (pwr_en_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       gbase_q <= GBASE_RST & BASE_ADDR_MSK;
    else if (wr && addr_i == OFS_GBASE) gbase_q <= wdata_i & BASE_ADDR_MSK;
  end

  assign gcr_base_o = gbase_q;
  assign cp0_base_o = gbase_q >> 4;

  always_comb begin
    rdata_d = '0;
    if (win != WIN_NONE) begin
      case (cl_ofs)
        CL_CFG:   rdata_d = CL_CFGV;
        CL_OTHER: rdata_d = DW'(oth_all[tgt]);
        CL_RBASE: rdata_d = rb_all[tgt];
        default:  rdata_d = '0;
      endcase
    end else begin
      case (addr_i)
        OFS_GCFG:    rdata_d = '0;
        OFS_GBASE:   rdata_d = gbase_q;
        OFS_REV:     rdata_d = REVISION;
        OFS_INTC:    rdata_d = intc_q;
        OFS_PWR:     rdata_d = pwr_q;
        OFS_INTC_ST: rdata_d = DW'(intc_present_i);
        OFS_PWR_ST:  rdata_d = DW'(pwr_present_i);
        OFS_L2CFG:   rdata_d = L2_BYPASS;
        default:     rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rdata_d;
    end
  end

  // R2
  rvalid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rvalid_o);
  // R3
  gcfg_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == OFS_GCFG) |=> (rdata_o == '0));
  // R11
  gbase_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && addr_i == OFS_GBASE) |=> $stable(gcr_base_o));
  // R13
  bad_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !id_ok && addr_i[15:13] == WIN_LOCAL) |=> (rdata_o == '0));
endmodule

// File: tb/cluster_cfg_regs_tb_top.sv
module cluster_cfg_regs_tb_top;
  localparam int N = 4;

  logic          clk = 0, rst_ni = 0;
  logic          req = 0, we = 0;
  logic [15:0]   addr = '0;
  logic [63:0]   wdata = '0;
  logic [2:0]    cid = '0;
  logic [63:0]   rdata;
  logic          rvalid;
  logic          intc_p = 1, pwr_p = 0;
  logic [63:0]   intc_base, pwr_base, gbase, cp0;
  logic          intc_en, pwr_en;
  logic [N*64-1:0] exc;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  cluster_cfg_regs #(.NUM_CORES(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .core_id_i(cid), .rdata_o(rdata), .rvalid_o(rvalid),
    .intc_present_i(intc_p), .pwr_present_i(pwr_p),
    .intc_base_o(intc_base), .intc_en_o(intc_en),
    .pwr_base_o(pwr_base), .pwr_en_o(pwr_en),
    .gcr_base_o(gbase), .cp0_base_o(cp0), .exc_base_o(exc));

  typedef struct packed {
    logic        w;
    logic [2:0]  c;
    logic [15:0] a;
    logic [63:0] d;
    logic [63:0] e;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VT [NV] = '{
    '{1'b0, 3'd0, 16'h0000, 64'h0, 64'h0},                     // R3 global cfg
    '{1'b0, 3'd0, 16'h0030, 64'h0, 64'h800},                   // R3 revision
    '{1'b0, 3'd0, 16'h0130, 64'h0, 64'h0010_0000},             // R4
    '{1'b0, 3'd2, 16'h2010, 64'h0, 64'd3},                     // R5 local
    '{1'b0, 3'd1, 16'h4010, 64'h0, 64'd3},                     // R5 other
    '{1'b1, 3'd0, 16'h2018, 64'd2, 64'h0},                     // R6 core0 other=2
    '{1'b1, 3'd0, 16'h4020, 64'h1234_5678_ABCD_EFFF, 64'h0},   // R7 rb of core2
    '{1'b0, 3'd2, 16'h2020, 64'h0, 64'hABCD_E000},             // R6 R12
    '{1'b0, 3'd0, 16'h4020, 64'h0, 64'hABCD_E000},             // R7
    '{1'b0, 3'd0, 16'h2020, 64'h0, 64'hBFC0_0000},             // R6 own set untouched
    '{1'b1, 3'd0, 16'h2018, 64'd5, 64'h0},                     // R8 reject
    '{1'b0, 3'd0, 16'h2018, 64'h0, 64'd2},                     // R8
    '{1'b1, 3'd1, 16'h2018, 64'hF3, 64'h0},                    // R8 masked 3 ok
    '{1'b0, 3'd1, 16'h2018, 64'h0, 64'd3},                     // R8
    '{1'b1, 3'd0, 16'h4018, 64'd1, 64'h0},                     // R7 core2 other=1
    '{1'b0, 3'd2, 16'h2018, 64'h0, 64'd1},                     // R7
    '{1'b0, 3'd0, 16'h4018, 64'h0, 64'd1},                     // R7
    '{1'b1, 3'd0, 16'h0080, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},   // R9 present
    '{1'b0, 3'd0, 16'h0080, 64'h0, 64'h0000_FFFF_FFFF_8001},   // R9
    '{1'b1, 3'd0, 16'h0088, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},   // R9 absent
    '{1'b0, 3'd0, 16'h0088, 64'h0, 64'h0},                     // R9
    '{1'b0, 3'd0, 16'h00D0, 64'h0, 64'd1},                     // R10
    '{1'b0, 3'd0, 16'h00F0, 64'h0, 64'd0},                     // R10
    '{1'b1, 3'd0, 16'h0008, 64'h1234_5678_9ABC_DEF0, 64'h0}    // R11
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] c, input logic [15:0] a, input logic [63:0] d);
    @(negedge clk);
    req = 1; we = 1; cid = c; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [2:0] c, input logic [15:0] a, output logic [63:0] q);
    @(negedge clk);
    req = 1; we = 0; cid = c; addr = a;
    @(negedge clk);
    req = 0;
    q = rdata;
    checks++;
    if (rvalid !== 1'b1) begin
      fails++;
      $display("FAIL R2: actual rvalid %b expected 1", rvalid);
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] q;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 intc_base", intc_base, 64'h0);
    chk("R1 intc_en", {63'h0, intc_en}, 64'h0);
    chk("R1 pwr_en", {63'h0, pwr_en}, 64'h0);
    chk("R1 gbase", gbase, 64'h1FBF_8000);
    for (int k = 0; k < N; k++) chk("R1 exc", exc[k*64 +: 64], 64'hFFFF_FFFF_BFC0_0000);
    chk("R1 rvalid idle", {63'h0, rvalid}, 64'h0);
    rd(3'd3, 16'h2018, q); chk("R1 other ptr", q, 64'h0);
    rd(3'd1, 16'h2020, q); chk("R1 rbase", q, 64'hBFC0_0000);
    rd(3'd0, 16'h0080, q); chk("R1 intc reg", q, 64'h0);

    for (int i = 0; i < NV; i++) begin
      if (VT[i].w) wr(VT[i].c, VT[i].a, VT[i].d);
      else begin
        rd(VT[i].c, VT[i].a, q);
        chk($sformatf("vector %0d", i), q, VT[i].e);
      end
    end

    // R11 global base and cp0 copy
    rd(3'd0, 16'h0008, q);
    chk("R11 gbase rd", q, 64'h0000_5678_9ABC_8000);
    chk("R11 cp0", cp0, 64'h0000_0567_89AB_C800);
    // R9 outputs
    chk("R9 intc_base", intc_base, 64'h0000_FFFF_FFFF_8000);
    chk("R9 intc_en", {63'h0, intc_en}, 64'h1);
    chk("R9 pwr_en absent", {63'h0, pwr_en}, 64'h0);
    pwr_p = 1;
    wr(3'd0, 16'h0088, 64'h0000_0000_0012_8000);
    chk("R9 pwr_base", pwr_base, 64'h0000_0000_0012_8000);
    chk("R9 pwr_en off", {63'h0, pwr_en}, 64'h0);
    rd(3'd0, 16'h00F0, q); chk("R10 pwr status", q, 64'd1);
    // R12 per-core exception base
    chk("R12 core2", exc[2*64 +: 64], 64'hFFFF_FFFF_ABCD_E000);
    chk("R12 core0", exc[0 +: 64], 64'hFFFF_FFFF_BFC0_0000);
    wr(3'd1, 16'h2020, 64'h7000_1FFF);
    chk("R12 positive", exc[1*64 +: 64], 64'h0000_0000_7000_1000);
    // R3 unlisted offset
    wr(3'd0, 16'h0500, 64'hDEAD_BEEF);
    rd(3'd0, 16'h0500, q); chk("R3 unlisted", q, 64'h0);
    // R13 out-of-range requester
    rd(3'd5, 16'h2010, q); chk("R13 read", q, 64'h0);
    wr(3'd5, 16'h2020, 64'h1111_1000);
    wr(3'd5, 16'h4020, 64'h2222_2000);
    for (int k = 0; k < N; k++) begin
      logic [63:0] e;
      e = (k == 1) ? 64'h7000_1000 : (k == 2) ? 64'hFFFF_FFFF_ABCD_E000 : 64'hFFFF_FFFF_BFC0_0000;
      chk("R13 exc unchanged", exc[k*64 +: 64], e);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule